// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Edge/Level Selection

This block holds the pending-request register for the request lines of a programmable interrupt controller. Each line is latched either on a rising transition (edge mode) or for as long as it stays high (level mode). The choice is made per line by a trigger-mode register. Writes to that register pass through a fixed per-instance enable pattern, so lines that may never be level-sensitive stay in edge mode. The block samples every request line once per clock and keeps the previously sampled level of each line, which it uses to detect rising transitions.

A downstream priority resolver reads two vectors. The first is the raw request register. The second is the pending vector, which is the request register with the lines blocked by the externally held mask removed. When the resolver acknowledges a line, it gives a strobe and a line index. An edge-mode line then drops its request. A level-mode line keeps its request, because the request follows the input pin. All control and status pins are plain wires with no handshake. Nothing flows as a stream, so there is no back-pressure.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_n` is low, the request register, the stored last levels and the trigger-mode register are all zero, so `irr_o`, `pend_o` and `mode_o` read 0.
- R2: When `mode_wr_i` is high at a clock edge, `mode_o` becomes `mode_wdata_i & MODE_WMASK` after that edge. The default mask is 0xF8, so lines 0 to 2 can never leave edge mode. A `mode_o` bit of 1 means level mode and 0 means edge mode.
- R3: On an edge-mode line, the request bit is set at the edge where the line is sampled high and its previous sample was low. A line that stays high does not set the bit again.
- R4: On a level-mode line, the request bit equals the level sampled at the most recent clock edge. It is set while the input is high and cleared at the first edge where the input is low.
- R5: An acknowledge (`ack_i` high, line number on `ack_idx_i`) clears the request bit of that line at the next edge, if the line is in edge mode.
- R6: An acknowledge of a level-mode line leaves its request bit unchanged.
- R7: On an edge-mode line, the input returning low does not clear a latched request bit.
- R8: `pend_o` equals `irr_o & ~imr_i` combinationally. A set mask bit does not prevent the line from being latched into `irr_o`.
- R9: If a new rising transition and an acknowledge of the same edge-mode line happen at the same edge, the request bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_LINES | Request lines, sampled each clock |
| imr_i | input | NUM_LINES | Mask bits; 1 removes the line from `pend_o` |
| mode_wr_i | input | 1 | Write strobe for the trigger-mode register |
| mode_wdata_i | input | NUM_LINES | Trigger-mode write data (1 = level) |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDX_W | Line number being acknowledged |
| irr_o | output | NUM_LINES | Request register |
| pend_o | output | NUM_LINES | Unmasked pending requests |
| mode_o | output | NUM_LINES | Trigger-mode register contents |

## Verification
The request register and the trigger-mode register update at the first clock edge after the stimulus is driven. `pend_o` follows the mask input in the same cycle and follows a request-register change once that change has landed. The driver applies every stimulus on the falling edge and pushes the expected values of all three outputs for the next rising edge. The monitor pops and compares them 1 ns after that rising edge, while the mask from the same step is still applied. The stimulus covers a mode switch through the write filter, level following, edge set, clear and hold, acknowledges of both kinds of line, masking, and an acknowledge that collides with a new edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  localparam int unsigned DEF_LINES = 8;
endpackage

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
  parameter int unsigned N     = 8,
  parameter logic [N-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_data & WMASK;
  end

  // R2: a write lands filtered by the enable pattern
  p_mode_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q == ($past(wr_data) & WMASK)));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_i,
  input  trig_e trig_i,
  input  logic  ack_hit_i,
  output logic  irr_o
);
  logic last_q;
  logic rise;

  assign rise = req_i & ~last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      irr_o  <= 1'b0;
    end else begin
      last_q <= req_i;
      if (trig_i == TRIG_LEVEL) irr_o <= req_i;
      else if (rise)            irr_o <= 1'b1;
      else if (ack_hit_i)       irr_o <= 1'b0;
    end
  end

  // R4/R6: level lines track the pin regardless of acknowledge
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i == TRIG_LEVEL) |=> (irr_o == $past(req_i)));

  // R3/R9: a rising transition always latches
  p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_i == TRIG_EDGE) && rise) |=> irr_o);

  // R5: acknowledge without a new edge clears an edge line
  p_edge_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_i == TRIG_EDGE) && ack_hit_i && !rise) |=> !irr_o);

  // R7: an edge line holds its request without acknowledge
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_i == TRIG_EDGE) && irr_o && !ack_hit_i) |=> irr_o);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int unsigned NUM_LINES = DEF_LINES,
  parameter logic [NUM_LINES-1:0] MODE_WMASK = 8'hF8,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] imr_i,
  input  logic                 mode_wr_i,
  input  logic [NUM_LINES-1:0] mode_wdata_i,
  input  logic                 ack_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  output logic [NUM_LINES-1:0] irr_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] ack_hit;

  irq_mode_reg #(.N(NUM_LINES), .WMASK(MODE_WMASK)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_i),
    .wr_data (mode_wdata_i),
    .mode_q  (mode_o)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign ack_hit[i] = ack_i && (ack_idx_i == IDX_W'(i));

    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (req_i[i]),
      .trig_i    (trig_e'(mode_o[i])),
      .ack_hit_i (ack_hit[i]),
      .irr_o     (irr_o[i])
    );
  end

  assign pend_o = irr_o & ~imr_i;

  // R2: lines outside the enable pattern never become level-sensitive
  p_fixed_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o & ~MODE_WMASK) == '0);

  // R5/R6: at most one line is acknowledged per cycle
  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit));
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam int N = 8;
  localparam logic [N-1:0] WM = 8'hF8;

  typedef struct {
    logic [N-1:0] irr;
    logic [N-1:0] pend;
    logic [N-1:0] mode;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_i = '0, imr_i = '0, mode_wdata_i = '0;
  logic mode_wr_i = 1'b0, ack_i = 1'b0;
  logic [2:0] ack_idx_i = '0;
  logic [N-1:0] irr_o, pend_o, mode_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb[$];

  logic [N-1:0] m_irr = '0, m_last = '0, m_mode = '0;

  always #2 clk = ~clk;

  irq_req_latch #(.NUM_LINES(N), .MODE_WMASK(WM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .imr_i(imr_i),
    .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
    .ack_i(ack_i), .ack_idx_i(ack_idx_i),
    .irr_o(irr_o), .pend_o(pend_o), .mode_o(mode_o)
  );

  task automatic cmp(string tag, logic [N-1:0] irr, logic [N-1:0] pend, logic [N-1:0] mode);
    checks++;
    if (irr_o !== irr || pend_o !== pend || mode_o !== mode) begin
      failures++;
      $display("FAIL %s: irr=%h pend=%h mode=%h expected irr=%h pend=%h mode=%h",
               tag, irr_o, pend_o, mode_o, irr, pend, mode);
    end
  endtask

  task automatic step(string tag, logic [N-1:0] req, logic [N-1:0] imr,
                      logic ack, logic [2:0] idx, logic wr, logic [N-1:0] wd);
    exp_t e;
    logic [N-1:0] nx;
    @(negedge clk);
    req_i = req; imr_i = imr; ack_i = ack; ack_idx_i = idx;
    mode_wr_i = wr; mode_wdata_i = wd;
    nx = m_irr;
    for (int i = 0; i < N; i++) begin
      if (m_mode[i])                 nx[i] = req[i];
      else if (req[i] && !m_last[i]) nx[i] = 1'b1;
      else if (ack && idx == i[2:0]) nx[i] = 1'b0;
    end
    m_irr = nx;
    m_last = req;
    if (wr) m_mode = wd & WM;
    e.irr = m_irr; e.pend = m_irr & ~imr; e.mode = m_mode; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, e.irr, e.pend, e.mode);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    req_i = 8'hFF; mode_wr_i = 1'b1; mode_wdata_i = 8'hFF;
    repeat (3) @(posedge clk);
    #1 cmp("R1 reset", '0, '0, '0);
    @(negedge clk);
    req_i = '0; mode_wr_i = 1'b0; mode_wdata_i = '0;
    rst_n = 1'b1;
    // R2: filtered mode write
    step("R2 mode write",   8'h00, 8'h00, 0, 0, 1, 8'hFF);
    // R4: level lines 3 and 4 follow the pins
    step("R4 level high",   8'h18, 8'h00, 0, 0, 0, 8'h00);
    step("R4 level drop",   8'h10, 8'h00, 0, 0, 0, 8'h00);
    // R3: edge line 0 rises
    step("R3 edge rise",    8'h11, 8'h00, 0, 0, 0, 8'h00);
    // R5: acknowledge of edge line 0
    step("R5 edge ack",     8'h11, 8'h00, 1, 0, 0, 8'h00);
    step("R3 held no reset",8'h11, 8'h00, 0, 0, 0, 8'h00);
    // R7: line 1 pulses and stays latched
    step("R7 edge up",      8'h12, 8'h00, 0, 0, 0, 8'h00);
    step("R7 edge low hold",8'h10, 8'h00, 0, 0, 0, 8'h00);
    // R6: acknowledge of level line 4
    step("R6 level ack",    8'h10, 8'h00, 1, 4, 0, 8'h00);
    // R8: masking leaves latching intact
    step("R8 mask pend",    8'h14, 8'h06, 0, 0, 0, 8'h00);
    step("R8 mask change",  8'h14, 8'h10, 0, 0, 0, 8'h00);
    // R9: edge and acknowledge on line 0 together
    step("R9 prep low",     8'h10, 8'h00, 0, 0, 0, 8'h00);
    step("R9 collide",      8'h11, 8'h00, 1, 0, 0, 8'h00);
    // R2: back to edge mode; R5 on former level line 4
    step("R2 mode clear",   8'h10, 8'h00, 0, 0, 1, 8'h00);
    step("R5 ack line4",    8'h10, 8'h00, 1, 4, 0, 8'h00);
    step("R3 line4 no re",  8'h10, 8'h00, 0, 0, 0, 8'h00);
    step("R5 ack line2",    8'h00, 8'h00, 1, 2, 0, 8'h00);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule